// File: doc/BRIEF.md
# CTS-Gated Serial Transmitter

This block takes bytes from an 8-bit processor bus and sends them as asynchronous serial characters. A written byte waits in a one-entry holding buffer. At the next bit-period boundary where the line is free, or where a stop bit is ending, the byte moves into the shifter and goes out as one low start bit, then 5 to 8 data bits with the least significant bit first, then one high stop bit. The bit period comes from a one-cycle `bit_tick` strobe that an external rate generator supplies.

Flow control works per character. The active-low clear-to-send pin passes through a two-flop synchronizer and is looked at only where a frame may begin. While it reads false, no new character starts. Pulling it false during a character never shortens that character. Two status outputs report an empty holding buffer and a fully drained transmitter.

Top module: `txser_cts`

## Requirements
- R1: After reset `txd` is 1. `txd` changes only on a clock edge where `bit_tick` is 1, and it stays 1 while no frame is in progress.
- R2: A frame is one start bit (0), then the data bits with bit 0 first, then one stop bit (1). Each bit lasts exactly one `bit_tick` period.
- R3: `len_code` selects the data length: 0→5, 1→6, 2→7, 3→8 bits. Byte bits above the selected length are not sent.
- R4: A frame starts only on a `bit_tick` edge where the holding buffer is full and the synchronized clear-to-send is true (`cts_n` low). While it is false, the byte stays in the buffer and `txd` stays 1.
- R5: If `cts_n` goes high during a frame, that frame still completes in full, and no further frame starts until `cts_n` is low again.
- R6: `hold_empty` is 1 after reset. It is 0 in the cycle after a write. It returns to 1 in the cycle after the frame start that takes the byte, unless a write happens in that same cycle. A write into a full buffer replaces the pending byte.
- R7: `tx_done` is 1 exactly when the holding buffer is empty and no frame is in progress, with its stop bit fully sent.
- R8: `cts_n` goes through two flops. A frame-start decision on an edge uses the pin value sampled two edges earlier.
- R9: If a byte is pending and clear-to-send is true when a stop bit ends, the next start bit follows at once, with no idle bit between the frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe marking each bit-period boundary |
| len_code | input | 2 | Data length code (0..3 → 5..8 bits) |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding buffer empty |
| tx_done | output | 1 | Buffer and shifter both empty |

## Verification
The bench builds the block with its default 8-bit width and a two-stage synchronizer. These are the only values for which the 5-to-8-bit length codes all make sense. They also place the clear-to-send decision exactly two edges behind the pin. `bit_tick` fires every fourth clock, so pin changes and writes can land between bit boundaries, on a boundary, and in the same cycle as a frame start. This exercises the write-wins overwrite case, back-to-back frames, and a clear-to-send pulse that the synchronizer delay moves before or after a decision point.

// File: rtl/txser_pkg.sv
package txser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } txst_e;

  // index of the final data bit for a length code (0..3 -> 4..7)
  function automatic logic [2:0] last_bit_idx(input logic [1:0] len_code);
    return 3'd4 + {1'b0, len_code};
  endfunction

  // a decision point is any bit boundary where the line is free or a stop bit ends
  function automatic logic at_boundary(input txst_e st);
    return (st == ST_IDLE) || (st == ST_STOP);
  endfunction

endpackage

// File: rtl/txser_sync.sv
module txser_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg <= {STAGES{RST_VAL}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/txser_hold.sv
module txser_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      // a write in the take cycle wins: the new byte is the pending one
      if (wr_en) begin
        full <= 1'b1;
        data <= wr_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/txser_shift.sv
module txser_shift
  import txser_pkg::*;
#(
  parameter int W  = 8,
  localparam int CW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic [1:0]   len_code,
  input  logic         cts_ok,
  input  logic         hold_full,
  input  logic [W-1:0] hold_data,
  output logic         txd,
  output logic         frame_start,
  output logic         busy
);
  txst_e        st;
  logic [W-1:0] sh;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last        = CW'(last_bit_idx(len_code));
  assign frame_start = bit_tick && hold_full && cts_ok && at_boundary(st);
  assign busy        = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      txd <= 1'b1;
      sh  <= '0;
      cnt <= '0;
    end else if (bit_tick) begin
      case (st)
        ST_IDLE, ST_STOP: begin
          if (frame_start) begin
            st  <= ST_START;
            txd <= 1'b0;
            sh  <= hold_data;
          end else begin
            st  <= ST_IDLE;
            txd <= 1'b1;
          end
        end
        ST_START: begin
          txd <= sh[0];
          sh  <= sh >> 1;
          cnt <= '0;
          st  <= ST_DATA;
        end
        default: begin
          if (cnt == last) begin
            txd <= 1'b1;
            st  <= ST_STOP;
          end else begin
            txd <= sh[0];
            sh  <= sh >> 1;
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/txser_cts.sv
module txser_cts #(
  parameter int W         = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_tick,
  input  logic [1:0]   len_code,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         cts_n,
  output logic         txd,
  output logic         hold_empty,
  output logic         tx_done
);
  logic         cts_pin_s;
  logic         cts_ok;
  logic         hold_full;
  logic [W-1:0] hold_data;
  logic         frame_start;
  logic         busy;

  txser_sync #(.STAGES(SYNC_STGS), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_pin_s)
  );
  assign cts_ok = ~cts_pin_s;

  txser_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(frame_start), .full(hold_full), .data(hold_data)
  );

  txser_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .len_code(len_code),
    .cts_ok(cts_ok), .hold_full(hold_full), .hold_data(hold_data),
    .txd(txd), .frame_start(frame_start), .busy(busy)
  );

  assign hold_empty = ~hold_full;
  assign tx_done    = ~hold_full & ~busy;
endmodule

// File: rtl/txser_chk.sv
module txser_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic wr_en,
  input logic txd,
  input logic hold_empty,
  input logic tx_done,
  input logic frame_start,
  input logic cts_ok,
  input logic busy
);
  AST_QUIET_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(txd)); // R1
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !txd); // R2
  AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (cts_ok && !hold_empty)); // R4
  AST_FRAME_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_tick) |=> busy); // R5
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty); // R6
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !wr_en) |=> hold_empty); // R6
  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> txd); // R7
endmodule

bind txser_cts txser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_en(wr_en),
  .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done),
  .frame_start(frame_start), .cts_ok(cts_ok), .busy(busy)
);

// File: tb/test_txser_cts.sv
module test_txser_cts;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cts_n = 1'b1;
  logic       txd, hold_empty, tx_done;

  int compared = 0;
  int mismatched = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  txser_cts i_txser_cts (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .len_code(len_code),
    .wr_en(wr_en), .wr_data(wr_data), .cts_n(cts_n),
    .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
  );

  // bit strobe every fourth clock
  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    bit_tick <= (tcnt == 0);
  end

  // behavioural reference: queue of pending line bits
  bit mq[$];
  bit mtxd = 1, mbusy = 0, mpend = 0, m1 = 1, m2 = 1;
  logic [7:0] mbyte = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      mtxd = 1; mbusy = 0; mpend = 0; m1 = 1; m2 = 1;
    end else begin
      if (bit_tick) begin
        if (mq.size() > 0) mtxd = mq.pop_front();
        else if (mpend && !m2) begin
          mtxd = 0;
          for (int i = 0; i < 5 + int'(len_code); i++) mq.push_back(mbyte[i]);
          mq.push_back(1'b1);
          mpend = 0;
          mbusy = 1;
        end else begin
          mtxd = 1;
          mbusy = 0;
        end
      end
      if (wr_en) begin mpend = 1; mbyte = wr_data; end
      m2 = m1;
      m1 = cts_n;
    end
  end

  task automatic check(input string t, input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, "txd", txd, mtxd);
      check("R6", "hold_empty", hold_empty, !mpend);
      check("R7", "tx_done", tx_done, !mpend && !mbusy);
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    for (int i = 0; i < 400 && tx_done !== 1'b1; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset txd", txd, 1'b1);
    check("R6", "reset hold_empty", hold_empty, 1'b1);
    check("R7", "reset tx_done", tx_done, 1'b1);

    // R2 basic frames
    tag = "R2";
    cts_n = 1'b0;
    repeat (3) @(negedge clk);
    write_byte(8'hA5); wait_done();
    write_byte(8'h3C); wait_done();

    // R3 all lengths
    tag = "R3";
    for (int l = 0; l < 4; l++) begin
      len_code = 2'(l);
      write_byte(8'hE6 ^ 8'(l * 37)); wait_done();
    end
    len_code = 2'd3;

    // R4 clear-to-send false holds the byte
    tag = "R4";
    cts_n = 1'b1;
    repeat (4) @(negedge clk);
    write_byte(8'h55);
    repeat (60) @(negedge clk);
    check("R4", "held txd", txd, 1'b1);
    check("R4", "held hold_empty", hold_empty, 1'b0);
    cts_n = 1'b0;
    wait_done();

    // R5 drop mid-frame
    tag = "R5";
    write_byte(8'h81);
    for (int i = 0; i < 100 && txd !== 1'b0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    cts_n = 1'b1;
    write_byte(8'h7E);
    repeat (80) @(negedge clk);
    check("R5", "no next frame txd", txd, 1'b1);
    check("R5", "next byte held", hold_empty, 1'b0);
    check("R5", "not done", tx_done, 1'b0);
    cts_n = 1'b0;
    wait_done();

    // R9 back-to-back and overwrite
    tag = "R9";
    write_byte(8'h0F);
    for (int i = 0; i < 100 && hold_empty !== 1'b1; i++) @(negedge clk);
    write_byte(8'hC3);
    write_byte(8'h96);
    wait_done();

    // R8 short clear-to-send pulses against the synchronizer
    tag = "R8";
    cts_n = 1'b1;
    repeat (4) @(negedge clk);
    write_byte(8'h2D);
    for (int k = 0; k < 6; k++) begin
      repeat (k + 3) @(negedge clk);
      cts_n = 1'b0;
      @(negedge clk);
      cts_n = 1'b1;
    end
    cts_n = 1'b0;
    wait_done();
    check("R8", "drained", tx_done, 1'b1);

    repeat (8) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule